// File: doc/BRIEF.md
# Write-Per-Bit Masked Burst Writer

This block is the write datapath on the device side of a 32-bit synchronous graphics memory. It watches the command pins on each rising clock edge and tracks which banks hold an open row. When a write command arrives for a bank whose row has been open long enough, it takes the first data word on that same edge. It then takes one more word on each following edge and turns every word into a single array write aimed at the next column of the burst.

A row can be opened in two ways. A normal activate writes every bit of a word unless the per-byte data mask blocks its byte. An activate with the special-function pin high opens the row in write-per-bit mode. Every write to that row is then also gated bit by bit by a loadable mask register. The burst length and the address ordering come from a mode register, which a mode-set command loads. A new write, a read, or a precharge of the bursting bank cuts a running burst short.

Top module: `sgram_wpb_writer`

## Requirements
- R1: A write is decoded when ras_n=1, cas_n=0, we_n=0, dsf=0 and addr[8]=0, and addr[7:0] gives the column. The same pins with addr[8]=1 produce no array write and no error.
- R2: A write is accepted only if its bank was activated at least TRCD (default 2) rising edges earlier. An earlier write produces no array write and pulses wr_err one cycle after its edge.
- R3: A write to a bank that has not been activated since reset, or that has been precharged, is rejected in the same way, with wr_err and no array write.
- R4: The word on dq at each accepted data edge appears one cycle later on arr_wdata, with arr_we high, the bank, the row stored at activate and the column. The first word is the one presented with the write command.
- R5: A mode-set command (ras_n=0, cas_n=0, we_n=0, dsf=0) loads the length code addr[2:0]. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 words, code 7 gives a full page, and the other codes give 1 word. Data presented after the last word of the burst is not written.
- R6: With addr[3]=0 at mode set, the columns advance sequentially and wrap inside the aligned block of burst length. With addr[3]=1 they follow start XOR index. A full-page burst is always sequential, wraps from column 255 to column 0, and runs until it is interrupted.
- R7: dqm[b]=1 clears arr_bit_en[8b+7:8b] for that word.
- R8: An activate (ras_n=0, cas_n=1, we_n=1) with dsf=1 marks its bank as masked, and writes to that bank AND arr_bit_en with the mask register. An activate with dsf=0 makes writes to that bank ignore the mask register.
- R9: With mask_ld=1, mask_in is loaded at the edge. Writes on that same edge still use the old value. The mask register resets to all ones.
- R10: A write command, a read command (ras_n=1, cas_n=0, we_n=1) or a precharge (ras_n=0, cas_n=1, we_n=0) that hits the bursting bank ends a running burst. A precharge hits the bursting bank when bs selects it or when addr[10]=1. A new write that is accepted writes its own first word on that edge.
- R11: After reset arr_we and wr_err are 0, all banks are idle, and the mode is a 1-word sequential burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| dsf | input | 1 | Special-function pin; on activate it selects write-per-bit mode |
| bs | input | 1 | Bank select |
| addr | input | 11 | Row, column, mode and control address |
| dq | input | 32 | Write data |
| dqm | input | 4 | Per-byte write block, 1 blocks the byte |
| mask_ld | input | 1 | Load strobe for the bit mask register |
| mask_in | input | 32 | New bit mask, 1 enables the bit |
| arr_we | output | 1 | Array write strobe |
| arr_bank | output | 1 | Bank of the array write |
| arr_row | output | 11 | Row of the array write |
| arr_col | output | 8 | Column of the array write |
| arr_wdata | output | 32 | Data of the array write |
| arr_bit_en | output | 32 | Per-bit write enable of the array write |
| wr_err | output | 1 | Pulses when a write command is rejected |

## Verification
The bench builds the block with its default parameters: two banks, TRCD of 2, 256 columns and a 32-bit word split into four bytes. Two banks let one row be open in masked mode while the other row is open normally, so both enable paths can be tested. TRCD of 2 means the one-cycle-early rejection and the first legal write are adjacent cycles. With 256 columns, a full-page burst that starts at column 254 crosses the page wrap within four words. The four-byte split lets one word mix a per-byte block with per-bit gating.

// File: rtl/sgram_wpb_pkg.sv
package sgram_wpb_pkg;

  typedef enum logic [2:0] {
    C_NOP,
    C_ACT,
    C_PRE,
    C_MRS,
    C_WRITE,
    C_READ
  } cmd_e;

  // Pin decode of one command edge; a_ctl is the write-variant address bit.
  function automatic cmd_e cmd_decode(input logic ras_n, input logic cas_n,
                                      input logic we_n, input logic dsf,
                                      input logic a_ctl);
    cmd_e c;
    case ({ras_n, cas_n, we_n})
      3'b011:  c = C_ACT;
      3'b010:  c = C_PRE;
      3'b000:  c = dsf ? C_NOP : C_MRS;
      3'b100:  c = (dsf || a_ctl) ? C_NOP : C_WRITE;
      3'b101:  c = dsf ? C_NOP : C_READ;
      default: c = C_NOP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sgram_wpb_bank.sv
module sgram_wpb_bank #(
  parameter int ROW_W = 11,
  parameter int TRCD  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             masked_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             ready_o,
  output logic             masked_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CNT_W = $clog2(TRCD + 1);

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             masked_q;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    open_d = open_q;
    if (act_i)      open_d = 1'b1;
    else if (pre_i) open_d = 1'b0;
    cnt_en = act_i || (open_q && (cnt_q < CNT_W'(TRCD)));
    cnt_d  = act_i ? CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masked_q <= 1'b0;
      row_q    <= '0;
    end else if (act_i) begin
      masked_q <= masked_i;
      row_q    <= row_i;
    end
  end

  assign ready_o  = open_q && (cnt_q >= CNT_W'(TRCD));
  assign masked_o = masked_q;
  assign row_o    = row_q;
endmodule

// File: rtl/sgram_wpb_burst.sv
module sgram_wpb_burst #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] blk_mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic             cont_o,
  output logic [COL_W-1:0] col_o
);
  logic             busy_q, busy_d;
  logic [COL_W-1:0] base_q, idx_q, idx_d, bmask_q;
  logic             full_q, ilv_q;
  logic [COL_W-1:0] offs, seq_col;
  logic             idx_en;

  always_comb begin
    cont_o  = busy_q && !stop_i && !start_i;
    offs    = ilv_q ? (base_q ^ idx_q) : (base_q + idx_q);
    seq_col = (base_q & ~bmask_q) | (offs & bmask_q);
    col_o   = cont_o ? seq_col : col_i;

    busy_d = busy_q;
    idx_d  = idx_q + COL_W'(1);
    idx_en = 1'b0;
    if (start_i) begin
      busy_d = (blk_mask_i != '0);
      idx_d  = COL_W'(1);
      idx_en = 1'b1;
    end else if (stop_i) begin
      busy_d = 1'b0;
    end else if (cont_o) begin
      if (!full_q && (idx_q == bmask_q)) busy_d = 1'b0;
      else                              idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      bmask_q <= '0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
    end else if (start_i) begin
      base_q  <= col_i;
      bmask_q <= blk_mask_i;
      full_q  <= full_i;
      ilv_q   <= ilv_i && !full_i;
    end
  end
endmodule

// File: rtl/sgram_wpb_merge.sv
module sgram_wpb_merge #(
  parameter int DQ_W   = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DQ_W / BYTE_W
) (
  input  logic [NB-1:0]   dqm_i,
  input  logic            masked_i,
  input  logic [DQ_W-1:0] mask_i,
  output logic [DQ_W-1:0] en_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [BYTE_W-1:0] bit_part;
    assign bit_part = masked_i ? mask_i[b*BYTE_W +: BYTE_W] : {BYTE_W{1'b1}};
    assign en_o[b*BYTE_W +: BYTE_W] = {BYTE_W{~dqm_i[b]}} & bit_part;
  end
endmodule

// File: rtl/sgram_wpb_writer.sv
module sgram_wpb_writer
  import sgram_wpb_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 11,
  parameter int COL_W     = 8,
  parameter int DQ_W      = 32,
  parameter int BYTE_W    = 8,
  parameter int TRCD      = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int NB       = DQ_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic [BANK_W-1:0] bs,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq,
  input  logic [NB-1:0]     dqm,
  input  logic              mask_ld,
  input  logic [DQ_W-1:0]   mask_in,
  output logic              arr_we,
  output logic [BANK_W-1:0] arr_bank,
  output logic [ADDR_W-1:0] arr_row,
  output logic [COL_W-1:0]  arr_col,
  output logic [DQ_W-1:0]   arr_wdata,
  output logic [DQ_W-1:0]   arr_bit_en,
  output logic              wr_err
);
  localparam int AP_BIT  = ADDR_W - 1;
  localparam int CTL_BIT = COL_W;

  // reset: asynchronous assert, synchronous release
  logic rst_s0, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s0    <= 1'b1;
      rst_int_n <= rst_s0;
    end
  end

  cmd_e cmd;
  assign cmd = cmd_decode(ras_n, cas_n, we_n, dsf, addr[CTL_BIT]);

  // bank state
  logic [NUM_BANKS-1:0] act_v, pre_v, bank_ready, bank_masked;
  logic [ADDR_W-1:0]    bank_row [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_v[b] = (cmd == C_ACT) && (bs == BANK_W'(b));
    assign pre_v[b] = (cmd == C_PRE) && (addr[AP_BIT] || (bs == BANK_W'(b)));
    sgram_wpb_bank #(.ROW_W(ADDR_W), .TRCD(TRCD)) u_bank (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .act_i    (act_v[b]),
      .pre_i    (pre_v[b]),
      .masked_i (dsf),
      .row_i    (addr),
      .ready_o  (bank_ready[b]),
      .masked_o (bank_masked[b]),
      .row_o    (bank_row[b])
    );
  end

  // mode register
  logic [2:0]       mode_code_q;
  logic             mode_ilv_q;
  logic             mode_full;
  logic [COL_W-1:0] blk_mask;
  logic             mrs;
  assign mrs = (cmd == C_MRS);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_code_q <= 3'd0;
      mode_ilv_q  <= 1'b0;
    end else if (mrs) begin
      mode_code_q <= addr[2:0];
      mode_ilv_q  <= addr[3];
    end
  end

  always_comb begin
    mode_full = 1'b0;
    blk_mask  = '0;
    if (mode_code_q == 3'd7) begin
      mode_full = 1'b1;
      blk_mask  = '1;
    end else if (!mode_code_q[2]) begin
      blk_mask = (COL_W'(1) << mode_code_q[1:0]) - COL_W'(1);
    end
  end

  // bit mask register
  logic [DQ_W-1:0] mask_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q <= '1;
    end else if (mask_ld) begin
      mask_q <= mask_in;
    end
  end

  // command acceptance and burst ownership
  logic              wr_cmd, wr_ok, wr_rej, pre_hit, stop, cont, wr_now;
  logic [BANK_W-1:0] bbank_q;
  logic [ADDR_W-1:0] brow_q;
  logic              bmasked_q;

  assign wr_cmd  = (cmd == C_WRITE);
  assign wr_ok   = wr_cmd && bank_ready[bs];
  assign wr_rej  = wr_cmd && !bank_ready[bs];
  assign pre_hit = (cmd == C_PRE) && (addr[AP_BIT] || (bs == bbank_q));
  assign stop    = wr_cmd || (cmd == C_READ) || pre_hit;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bbank_q   <= '0;
      brow_q    <= '0;
      bmasked_q <= 1'b0;
    end else if (wr_ok) begin
      bbank_q   <= bs;
      brow_q    <= bank_row[bs];
      bmasked_q <= bank_masked[bs];
    end
  end

  logic [COL_W-1:0] cur_col;
  sgram_wpb_burst #(.COL_W(COL_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (wr_ok),
    .stop_i     (stop),
    .col_i      (addr[COL_W-1:0]),
    .blk_mask_i (blk_mask),
    .full_i     (mode_full),
    .ilv_i      (mode_ilv_q),
    .cont_o     (cont),
    .col_o      (cur_col)
  );

  logic [BANK_W-1:0] cur_bank;
  logic [ADDR_W-1:0] cur_row;
  logic              cur_masked;
  logic [DQ_W-1:0]   cur_en;

  assign wr_now     = wr_ok || cont;
  assign cur_bank   = wr_ok ? bs : bbank_q;
  assign cur_row    = wr_ok ? bank_row[bs] : brow_q;
  assign cur_masked = wr_ok ? bank_masked[bs] : bmasked_q;

  sgram_wpb_merge #(.DQ_W(DQ_W), .BYTE_W(BYTE_W)) u_merge (
    .dqm_i    (dqm),
    .masked_i (cur_masked),
    .mask_i   (mask_q),
    .en_o     (cur_en)
  );

  // array write port
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      arr_we <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      arr_we <= wr_now;
      wr_err <= wr_rej;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      arr_bank   <= '0;
      arr_row    <= '0;
      arr_col    <= '0;
      arr_wdata  <= '0;
      arr_bit_en <= '0;
    end else if (wr_now) begin
      arr_bank   <= cur_bank;
      arr_row    <= cur_row;
      arr_col    <= cur_col;
      arr_wdata  <= dq;
      arr_bit_en <= cur_en;
    end
  end
endmodule

// File: rtl/sgram_wpb_chk.sv
module sgram_wpb_chk #(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 8,
  parameter int DQ_W   = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DQ_W / BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dsf,
  input logic [ADDR_W-1:0] addr,
  input logic [DQ_W-1:0]   dq,
  input logic [NB-1:0]     dqm,
  input logic              arr_we,
  input logic [DQ_W-1:0]   arr_wdata,
  input logic [DQ_W-1:0]   arr_bit_en,
  input logic              wr_err
);
  logic wr_pins;
  assign wr_pins = ras_n && !cas_n && !we_n && !dsf && !addr[COL_W];

  AST_BURST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_we) |-> $past(wr_pins)); // R1

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> !arr_we); // R2

  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_pins)); // R3

  AST_DATA_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_wdata == $past(dq))); // R4

  for (genvar b = 0; b < NB; b++) begin : g_dqm
    AST_DQM_BYTE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(dqm[b])) |-> (arr_bit_en[b*BYTE_W +: BYTE_W] == '0)); // R7
  end
endmodule

bind sgram_wpb_writer sgram_wpb_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .DQ_W(DQ_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .dsf        (dsf),
  .addr       (addr),
  .dq         (dq),
  .dqm        (dqm),
  .arr_we     (arr_we),
  .arr_wdata  (arr_wdata),
  .arr_bit_en (arr_bit_en),
  .wr_err     (wr_err)
);

// File: tb/sim_sgram_wpb_writer.sv
`timescale 1ns/1ps
module sim_sgram_wpb_writer;
  localparam logic [2:0] K_NOP = 3'd0, K_ACT = 3'd1, K_ACTM = 3'd2, K_WR = 3'd3,
                         K_RD = 3'd4, K_PRE = 3'd5, K_MRS = 3'd6;

  typedef struct packed {
    logic [2:0]  cmd;
    logic        bank;
    logic [10:0] addr;
    logic [31:0] dq;
    logic [3:0]  dqm;
    logic        ewe;
    logic        ebank;
    logic [7:0]  ecol;
    logic [31:0] een;
    logic        eerr;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{K_MRS, 1'b0, 11'h002, 32'h0,         4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R5 BL4 seq
    '{K_ACT, 1'b0, 11'h055, 32'h0,         4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0},
    '{K_WR,  1'b0, 11'h010, 32'h11111111,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b1}, // R2 early
    '{K_WR,  1'b0, 11'h00E, 32'hA0A00001,  4'h0, 1'b1, 1'b0, 8'h0E, 32'hFFFFFFFF,  1'b0}, // R1 R4
    '{K_NOP, 1'b0, 11'h000, 32'hA0A00002,  4'h1, 1'b1, 1'b0, 8'h0F, 32'hFFFFFF00,  1'b0}, // R7
    '{K_NOP, 1'b0, 11'h000, 32'hA0A00003,  4'h0, 1'b1, 1'b0, 8'h0C, 32'hFFFFFFFF,  1'b0}, // R6 wrap in block
    '{K_NOP, 1'b0, 11'h000, 32'hA0A00004,  4'h0, 1'b1, 1'b0, 8'h0D, 32'hFFFFFFFF,  1'b0},
    '{K_NOP, 1'b0, 11'h000, 32'hA0A00005,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R5 extra ignored
    '{K_WR,  1'b1, 11'h020, 32'h22222222,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b1}, // R3 idle bank
    '{K_MRS, 1'b0, 11'h00A, 32'h0,         4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R6 interleave
    '{K_ACTM,1'b1, 11'h003, 32'h0,         4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0},
    '{K_NOP, 1'b0, 11'h000, 32'h0,         4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0},
    '{K_WR,  1'b1, 11'h005, 32'hB0B00001,  4'h8, 1'b1, 1'b1, 8'h05, 32'h00FF0F0F,  1'b0}, // R8 R7
    '{K_NOP, 1'b0, 11'h000, 32'hB0B00002,  4'h0, 1'b1, 1'b1, 8'h04, 32'hFFFF0F0F,  1'b0}, // R6 xor
    '{K_WR,  1'b0, 11'h020, 32'hC0C00001,  4'h0, 1'b1, 1'b0, 8'h20, 32'hFFFFFFFF,  1'b0}, // R10 new write
    '{K_RD,  1'b0, 11'h000, 32'hC0C00002,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R10 read stops
    '{K_NOP, 1'b0, 11'h000, 32'hC0C00003,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0},
    '{K_MRS, 1'b0, 11'h007, 32'h0,         4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R6 full page
    '{K_WR,  1'b0, 11'h0FE, 32'hD0D00001,  4'h0, 1'b1, 1'b0, 8'hFE, 32'hFFFFFFFF,  1'b0},
    '{K_NOP, 1'b0, 11'h000, 32'hD0D00002,  4'h0, 1'b1, 1'b0, 8'hFF, 32'hFFFFFFFF,  1'b0},
    '{K_NOP, 1'b0, 11'h000, 32'hD0D00003,  4'h0, 1'b1, 1'b0, 8'h00, 32'hFFFFFFFF,  1'b0}, // R6 page wrap
    '{K_NOP, 1'b0, 11'h000, 32'hD0D00004,  4'h0, 1'b1, 1'b0, 8'h01, 32'hFFFFFFFF,  1'b0},
    '{K_PRE, 1'b0, 11'h000, 32'hD0D00005,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R10 precharge
    '{K_WR,  1'b0, 11'h010, 32'h33333333,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b1}, // R3 closed bank
    '{K_MRS, 1'b0, 11'h000, 32'h0,         4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R5 BL1
    '{K_WR,  1'b1, 11'h033, 32'hE0E00001,  4'h0, 1'b1, 1'b1, 8'h33, 32'hFFFF0F0F,  1'b0},
    '{K_NOP, 1'b0, 11'h000, 32'hE0E00002,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R5
    '{K_WR,  1'b1, 11'h133, 32'h44444444,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R1 A8 high
    '{K_MRS, 1'b0, 11'h005, 32'h0,         4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}, // R5 reserved
    '{K_WR,  1'b1, 11'h040, 32'hF0F00001,  4'h0, 1'b1, 1'b1, 8'h40, 32'hFFFF0F0F,  1'b0},
    '{K_NOP, 1'b0, 11'h000, 32'hF0F00002,  4'h0, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0}  // R5
  };

  logic clk, rst_n, ras_n, cas_n, we_n, dsf, bs, mask_ld;
  logic [10:0] addr;
  logic [31:0] dq, mask_in;
  logic [3:0]  dqm;
  logic        arr_we, arr_bank, wr_err;
  logic [10:0] arr_row;
  logic [7:0]  arr_col;
  logic [31:0] arr_wdata, arr_bit_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sgram_wpb_writer u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dsf(dsf), .bs(bs), .addr(addr), .dq(dq), .dqm(dqm),
    .mask_ld(mask_ld), .mask_in(mask_in),
    .arr_we(arr_we), .arr_bank(arr_bank), .arr_row(arr_row), .arr_col(arr_col),
    .arr_wdata(arr_wdata), .arr_bit_en(arr_bit_en), .wr_err(wr_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, take one rising edge, return at the next negedge
  task automatic cyc(input logic [2:0] c, input logic b, input logic [10:0] a,
                     input logic [31:0] d, input logic [3:0] m);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; dsf = 1'b0;
    case (c)
      K_ACT:   begin ras_n = 1'b0; end
      K_ACTM:  begin ras_n = 1'b0; dsf = 1'b1; end
      K_WR:    begin cas_n = 1'b0; we_n = 1'b0; end
      K_RD:    begin cas_n = 1'b0; end
      K_PRE:   begin ras_n = 1'b0; we_n = 1'b0; end
      K_MRS:   begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; end
      default: ;
    endcase
    bs = b; addr = a; dq = d; dqm = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_write(input string tag, input logic [7:0] col, input logic [31:0] en,
                           input logic [31:0] d, input logic b, input logic [10:0] row);
    chk({tag, " we"}, 32'(arr_we), 32'd1);
    chk({tag, " col"}, 32'(arr_col), 32'(col));
    chk({tag, " bit_en"}, arr_bit_en, en);
    chk({tag, " data"}, arr_wdata, d);
    chk({tag, " bank"}, 32'(arr_bank), 32'(b));
    chk({tag, " row"}, 32'(arr_row), 32'(row));
  endtask

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; dsf = 1'b0;
    bs = 1'b0; addr = '0; dq = '0; dqm = '0; mask_ld = 1'b0; mask_in = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset we", 32'(arr_we), 32'd0);
    chk("R11 reset err", 32'(wr_err), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // load the bit mask used by the table
    mask_ld = 1'b1; mask_in = 32'hFFFF0F0F;
    cyc(K_NOP, 1'b0, 11'h0, 32'h0, 4'h0);
    mask_ld = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = TBL[i];
      tag = $sformatf("vec%0d", i);
      cyc(v.cmd, v.bank, v.addr, v.dq, v.dqm);
      chk({tag, " R4 we"}, 32'(arr_we), 32'(v.ewe));
      chk({tag, " R2 err"}, 32'(wr_err), 32'(v.eerr));
      if (v.ewe)
        chk_write({tag, " R4"}, v.ecol, v.een, v.dq, v.ebank,
                  v.ebank ? 11'h003 : 11'h055);
    end

    // R9: load on the write edge uses the old mask, the next write the new one
    mask_ld = 1'b1; mask_in = 32'h0000FFFF;
    cyc(K_WR, 1'b1, 11'h050, 32'h12340001, 4'h0);
    mask_ld = 1'b0;
    chk_write("R9 old mask", 8'h50, 32'hFFFF0F0F, 32'h12340001, 1'b1, 11'h003);
    cyc(K_WR, 1'b1, 11'h051, 32'h12340002, 4'h0);
    chk_write("R9 new mask", 8'h51, 32'h0000FFFF, 32'h12340002, 1'b1, 11'h003);

    // R8: normal activate ignores the mask register
    cyc(K_ACT, 1'b1, 11'h007, 32'h0, 4'h0);
    cyc(K_NOP, 1'b0, 11'h000, 32'h0, 4'h0);
    cyc(K_WR, 1'b1, 11'h060, 32'h56780001, 4'h0);
    chk_write("R8 normal row", 8'h60, 32'hFFFFFFFF, 32'h56780001, 1'b1, 11'h007);

    // R11: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset we", 32'(arr_we), 32'd0);
    chk("R11 reset err", 32'(wr_err), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc(K_WR, 1'b1, 11'h010, 32'h0, 4'h0);
    chk("R11 banks idle err", 32'(wr_err), 32'd1);
    chk("R11 banks idle we", 32'(arr_we), 32'd0);

    // R9 reset value all ones, R11 default burst length one
    cyc(K_ACTM, 1'b1, 11'h009, 32'h0, 4'h0);
    cyc(K_NOP, 1'b0, 11'h000, 32'h0, 4'h0);
    cyc(K_WR, 1'b1, 11'h070, 32'h9ABC0001, 4'h0);
    chk_write("R9 reset mask", 8'h70, 32'hFFFFFFFF, 32'h9ABC0001, 1'b1, 11'h009);
    cyc(K_NOP, 1'b0, 11'h000, 32'h9ABC0002, 4'h0);
    chk("R11 default BL1", 32'(arr_we), 32'd0);

    // R10: precharge-all ends a two-word burst
    cyc(K_MRS, 1'b0, 11'h001, 32'h0, 4'h0);
    cyc(K_WR, 1'b1, 11'h080, 32'h77770001, 4'h0);
    chk_write("R10 BL2 first", 8'h80, 32'hFFFFFFFF, 32'h77770001, 1'b1, 11'h009);
    cyc(K_PRE, 1'b0, 11'h400, 32'h77770002, 4'h0);
    chk("R10 precharge all stops", 32'(arr_we), 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule